// File: doc/BRIEF.md
# Quadrature Event Tally with Threshold Interrupt

This block sits behind up to three quadrature decoders. Each decoder hands it a one-cycle event strobe for every step it detects. The block sums these strobes into a running tally. When the tally reaches a programmed number of events, it sets a sticky status flag and, if enabled, drives an interrupt. Decoding of the A/B lines, pin selection and the bus protocol are handled elsewhere. This block sees only the qualified strobes and a simple write strobe that carries a 16-bit control word.

The control word carries four fields:

| Bit(s) | Field | Behaviour |
|--------|-------|-----------|
| 0 | interrupt enable | stored on every write |
| 1 | status clear | write 1 to clear |
| 2 | tally reset | write 1 to reset |
| 13:3 | threshold | stored on every write |

The threshold holds the event count minus one. The tally is kept internally one bit wider than the threshold, so any threshold can be reached. The readable count is that tally clamped to 8 bits.

Top module: `qdec_evt_irq`

## Requirements
- R1: On each clock, the tally grows by the number of `evt_i` bits set in that cycle, so simultaneous events on several channels are all counted.
- R2: The internal tally saturates at 4095 and does not wrap. `count_o` shows the tally, clamped at 255.
- R3: A write with bit 2 set zeroes the tally. Events in the same cycle are then counted from zero.
- R4: `status_o` goes to 1 in the cycle after the tally first moves from below threshold+1 to threshold+1 or above, where threshold is the value stored before that write. This happens whatever the enable bit holds.
- R5: A write with bit 1 set clears `status_o`. A write with bit 1 clear leaves it unchanged. If the clear and a new crossing fall in the same cycle, the flag stays set.
- R6: `irq_o` equals `status_o` AND the stored enable bit.
- R7: Every write stores bit 0 as the enable and bits 13:3 as the threshold. `ctrl_o` reads back the enable in bit 0, the status in bit 1, 0 in bit 2, the threshold in bits 13:3 and 0 in bits 15:14.
- R8: After reset, the tally, status, enable and threshold are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| evt_i | input | 3 | one event strobe per channel (X, Y, Z) |
| wr_i | input | 1 | control write strobe |
| wdata_i | input | 16 | control write data |
| ctrl_o | output | 16 | control readback |
| count_o | output | 8 | clamped event tally |
| status_o | output | 1 | sticky threshold-reached flag |
| irq_o | output | 1 | masked interrupt |

## Verification
The assertions assume that every `evt_i` bit is a one-cycle qualified strobe. They also assume that `wr_i` and `wdata_i` are stable across each rising edge. The bench drives all inputs on the falling edge only.

The stimulus mixes several patterns:
- random strobes on any combination of channels;
- writes in which the clear bits are set on their own or together;
- status clears placed on the exact cycle of a crossing;
- a long all-channel burst that drives the tally into saturation.

// File: rtl/qdec_evt_pkg.sv
package qdec_evt_pkg;
  localparam int unsigned CTRL_W   = 16;
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned STAT_BIT = 1;
  localparam int unsigned CLR_BIT  = 2;
  localparam int unsigned THR_LSB  = 3;
endpackage

// File: rtl/qdec_evt_sum.sv
module qdec_evt_sum #(
  parameter int unsigned N_CH  = 3,
  localparam int unsigned NUM_W = $clog2(N_CH + 1)
) (
  input  logic [N_CH-1:0]  evt_i,
  output logic [NUM_W-1:0] num_o
);
  always_comb begin
    num_o = '0;
    for (int i = 0; i < int'(N_CH); i++) num_o = num_o + NUM_W'(evt_i[i]);
  end
endmodule

// File: rtl/qdec_evt_tally.sv
module qdec_evt_tally #(
  parameter int unsigned N_CH  = 3,
  parameter int unsigned THR_W = 11,
  localparam int unsigned NUM_W = $clog2(N_CH + 1),
  localparam int unsigned TAL_W = THR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [THR_W-1:0] thr_i,
  output logic [TAL_W-1:0] tally_o,
  output logic             hit_o
);
  logic [TAL_W-1:0] tally_q, base, nxt, limit;
  logic [TAL_W:0]   sum;

  always_comb begin
    base  = clr_i ? '0 : tally_q;
    sum   = {1'b0, base} + (TAL_W + 1)'(num_i);
    nxt   = sum[TAL_W] ? '1 : sum[TAL_W-1:0];
    limit = {1'b0, thr_i} + TAL_W'(1);
    hit_o = (base < limit) && (nxt >= limit);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) tally_q <= '0;
    else         tally_q <= nxt;

  assign tally_o = tally_q;

  p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (int'(tally_q) - int'($past(tally_q)) >= 0) &&
               (int'(tally_q) - int'($past(tally_q)) <= int'(N_CH)));
  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && tally_q == {TAL_W{1'b1}}) |=> tally_q == {TAL_W{1'b1}});
  p_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> int'(tally_q) <= int'(N_CH));
endmodule

// File: rtl/qdec_ctrl_regs.sv
module qdec_ctrl_regs
  import qdec_evt_pkg::*;
#(
  parameter int unsigned THR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              hit_i,
  output logic              en_o,
  output logic [THR_W-1:0]  thr_o,
  output logic              status_o,
  output logic              cnt_clr_o
);
  logic en_q, st_q;
  logic [THR_W-1:0] thr_q;
  logic st_clr;

  assign st_clr    = wr_i & wdata_i[STAT_BIT];
  assign cnt_clr_o = wr_i & wdata_i[CLR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      en_q  <= 1'b0;
      thr_q <= '0;
    end else if (wr_i) begin
      en_q  <= wdata_i[EN_BIT];
      thr_q <= wdata_i[THR_LSB +: THR_W];
    end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     st_q <= 1'b0;
    else if (hit_i)  st_q <= 1'b1;
    else if (st_clr) st_q <= 1'b0;

  assign en_o     = en_q;
  assign thr_o    = thr_q;
  assign status_o = st_q;

  p_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> st_q);
  p_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_clr && !hit_i) |=> !st_q);
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!st_clr && !hit_i) |=> $stable(st_q));
  p_wr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (en_q == $past(wdata_i[EN_BIT])));
endmodule

// File: rtl/qdec_evt_irq.sv
module qdec_evt_irq
  import qdec_evt_pkg::*;
#(
  parameter int unsigned N_CH  = 3,
  parameter int unsigned CNT_W = 8,
  parameter int unsigned THR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   evt_i,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              status_o,
  output logic              irq_o
);
  localparam int unsigned NUM_W = $clog2(N_CH + 1);
  localparam int unsigned TAL_W = THR_W + 1;

  logic [NUM_W-1:0] num;
  logic [TAL_W-1:0] tally;
  logic [THR_W-1:0] thr;
  logic en, st, hit, cnt_clr;

  qdec_evt_sum #(.N_CH(N_CH)) u_sum (.evt_i(evt_i), .num_o(num));

  qdec_evt_tally #(.N_CH(N_CH), .THR_W(THR_W)) u_tally (
    .clk_i, .rst_ni, .clr_i(cnt_clr), .num_i(num), .thr_i(thr),
    .tally_o(tally), .hit_o(hit));

  qdec_ctrl_regs #(.THR_W(THR_W)) u_regs (
    .clk_i, .rst_ni, .wr_i, .wdata_i, .hit_i(hit),
    .en_o(en), .thr_o(thr), .status_o(st), .cnt_clr_o(cnt_clr));

  generate
    if (CNT_W < TAL_W) begin : g_clamp
      assign count_o = (|tally[TAL_W-1:CNT_W]) ? '1 : tally[CNT_W-1:0];
    end else begin : g_wide
      assign count_o = CNT_W'(tally);
    end
  endgenerate

  always_comb begin
    ctrl_o = '0;
    ctrl_o[EN_BIT]                = en;
    ctrl_o[STAT_BIT]              = st;
    ctrl_o[THR_LSB +: THR_W]      = thr;
  end

  assign status_o = st;
  assign irq_o    = st & en;

  p_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> status_o);
endmodule

// File: tb/qdec_evt_irq_tb_top.sv
module qdec_evt_irq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] evt = '0;
  logic wr = 1'b0;
  logic [15:0] wd = '0;
  logic [15:0] ctrl;
  logic [7:0] cnt;
  logic st, irq;

  always #10 clk = ~clk;

  qdec_evt_irq dut_i (.clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .wr_i(wr),
    .wdata_i(wd), .ctrl_o(ctrl), .count_o(cnt), .status_o(st), .irq_o(irq));

  int checks = 0, fails = 0;
  int m_tally = 0, m_thr = 0;
  bit m_st = 0, m_en = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tally = 0; m_thr = 0; m_st = 0; m_en = 0;
    end else begin
      int n, base, nxt;
      bit hit;
      n    = int'(evt[0]) + int'(evt[1]) + int'(evt[2]);
      base = (wr && wd[2]) ? 0 : m_tally;                 // R3
      nxt  = (base + n > 4095) ? 4095 : base + n;          // R1 R2
      hit  = (base < m_thr + 1) && (nxt >= m_thr + 1);     // R4
      if (hit) m_st = 1;
      else if (wr && wd[1]) m_st = 0;                      // R5
      if (wr) begin m_en = wd[0]; m_thr = int'(wd[13:3]); end  // R7
      m_tally = nxt;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1/R2 count", int'(cnt), (m_tally > 255) ? 255 : m_tally);
    chk("R4/R5 status", int'(st), int'(m_st));
    chk("R6 irq", int'(irq), int'(m_st & m_en));
    chk("R7 ctrl", int'(ctrl), (m_thr << 3) | (int'(m_st) << 1) | int'(m_en));
  endtask

  // compare every cycle, away from the rising edge
  always @(negedge clk) if (rst_n) compare_all();

  task automatic step(logic [2:0] e, logic w, logic [15:0] d);
    @(negedge clk);
    #1;
    evt = e; wr = w; wd = d;
  endtask

  function automatic logic [15:0] cw(int thr, bit en, bit sclr, bit cclr);
    return 16'((thr << 3) | (int'(cclr) << 2) | (int'(sclr) << 1) | int'(en));
  endfunction

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 count", int'(cnt), 0);
    chk("R8 ctrl", int'(ctrl), 0);
    chk("R8 irq", int'(irq), 0);
    rst_n = 1'b1;
    // R4: thr=0 with enable off, one event sets status, irq stays low (R6)
    step(3'b001, 1'b0, '0);
    step(3'b000, 1'b0, '0);
    step(3'b000, 1'b0, '0);
    chk("R4 status no-enable", int'(st), 1);
    chk("R6 irq masked", int'(irq), 0);
    // R6: enable, then R5 clear
    step(3'b000, 1'b1, cw(9, 1, 0, 0));
    step(3'b000, 1'b0, '0);
    chk("R6 irq enabled", int'(irq), 1);
    step(3'b000, 1'b1, cw(9, 1, 1, 1));
    step(3'b000, 1'b0, '0);
    chk("R5 cleared", int'(st), 0);
    chk("R3 tally zero", int'(cnt), 0);
    // R1 simultaneous events: 3+2 = 5
    step(3'b111, 1'b0, '0);
    step(3'b101, 1'b0, '0);
    step(3'b000, 1'b0, '0);
    chk("R1 multi", int'(cnt), 5);
    // R5 set wins: thr=9, count at 5 + 3 + 2 = 10 crossing while clearing
    step(3'b111, 1'b0, '0);
    step(3'b011, 1'b1, cw(9, 1, 1, 0));
    step(3'b000, 1'b0, '0);
    chk("R5 set wins", int'(st), 1);
    // R3 clear with same-cycle events
    step(3'b110, 1'b1, cw(4, 0, 1, 1));
    step(3'b000, 1'b0, '0);
    chk("R3 clr+evt", int'(cnt), 2);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic w;
      logic [15:0] d;
      w = ($urandom % 8) == 0;
      d = cw(int'($urandom % 24), bit'($urandom % 2), bit'($urandom % 2),
             bit'(($urandom % 4) == 0));
      step(3'($urandom), w, d);
    end
    // R2 saturation: high threshold, long full-rate burst
    step(3'b000, 1'b1, cw(2047, 1, 1, 1));
    for (int i = 0; i < 1500; i++) step(3'b111, 1'b0, '0);
    step(3'b000, 1'b0, '0);
    step(3'b000, 1'b0, '0);
    chk("R2 clamp", int'(cnt), 255);
    chk("R4 high thr reached", int'(st), 1);
    repeat (3) step(3'b000, 1'b0, '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule